// File: doc/BRIEF.md
# Per-Sector ECC Status Aggregator

After a page has been read through a hardware error-correction engine, that engine leaves one 64-bit status word per correction step (sector) in a small buffer. This block walks those words and condenses them into a page verdict. On a start pulse it polls one status word until that word's completion flag appears. For a corrected page read this is the word of the final sector; for a raw transfer it is word 0. It then visits the sectors in ascending order and extracts each sector's corrected-bit count. It reports the largest per-sector count, the sum of all counts, and whether any sector was beyond repair. The two spare user bytes carried by each healthy sector are streamed out as the scan passes them.

The status words are fetched through a plain indexed read port with a one-cycle read latency, so the block can sit next to any small RAM or register file. A programmable poll limit stops the wait for a page that never completes and raises a timeout flag. All results appear together with a single-cycle done strobe and stay valid until the next start.

Top module: `ecc_sector_scan`

## Requirements
- R1: A start pulse accepted while idle clears the maximum, the total, the uncorrectable flag and the timeout flag by the next cycle. After done, all results hold their values until the next accepted start.
- R2: Only bit 31 of the polled word gates the scan. The polled word is index `num_steps-1` when `raw_mode` is 0 and index 0 when `raw_mode` is 1. Bit 31 of every other word has no effect.
- R3: If `timeout_limit` consecutive poll reads (a limit of 0 behaves as 1) all return bit 31 clear, the block asserts `timeout` and done. It scans no sector, and both the maximum and the total are 0.
- R4: The block takes `rd_data` as the word addressed by `rd_addr` in the cycle after `rd_en`. It issues exactly one read per poll attempt plus one per scanned sector, and no read while done is high.
- R5: The corrected-bit count of a sector is bits [29:24] of its word. `max_flips` equals the largest count among the scanned healthy sectors.
- R6: `total_flips` equals the sum of the counts of the scanned healthy sectors.
- R7: A count of 6'h3F marks a sector as uncorrectable. On the first such sector the block sets `uncorrectable` and stops the scan. Maximum and total then reflect only the earlier sectors.
- R8: For each healthy sector scanned, `ub_valid` pulses for one cycle. The pulse carries the sector index, with `ub_byte0` = bits [7:0] and `ub_byte1` = bits [15:8]. Sectors appear in ascending index order.
- R9: The zero-bit count in bits [21:16] and all other bits of a status word outside [31], [29:24] and [15:0] have no effect on any output.
- R10: With `raw_mode` = 1, once word 0 shows completion the block signals done without scanning any sector. The maximum and the total stay 0.
- R11: `done` is high for exactly one cycle per accepted start.
- R12: A start pulse while a scan is in progress is ignored and leaves that scan's results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| raw_mode | input | 1 | 1: poll word 0 and skip the sector scan |
| num_steps | input | 7 | Number of sectors in the page (1..MAX_STEPS) |
| timeout_limit | input | 16 | Poll reads allowed before giving up |
| rd_en | output | 1 | Status word read request |
| rd_addr | output | 6 | Status word index |
| rd_data | input | 64 | Status word, valid the cycle after rd_en |
| done | output | 1 | One-cycle completion strobe |
| timeout | output | 1 | Completion never seen within the limit |
| uncorrectable | output | 1 | A sector reported the failure code |
| max_flips | output | 6 | Largest per-sector corrected count |
| total_flips | output | 12 | Sum of per-sector corrected counts |
| ub_valid | output | 1 | User bytes of one sector are presented |
| ub_index | output | 6 | Sector index of the user bytes |
| ub_byte0 | output | 8 | First user byte (bits [7:0]) |
| ub_byte1 | output | 8 | Second user byte (bits [15:8]) |

## Verification
The bench gives the intermediate words random completion bits, so a design that waited on every sector, or on the wrong word, would stall or time out. It places the failure code at the first sector, the last sector and a random sector. A design that kept scanning past a failure would inflate the total and emit extra user bytes. It counts poll reads against the limit, including a limit of zero, where an off-by-one would show up as one poll too many or too few. Pages whose sectors all carry count 62 exercise the widest sum, and random zero-count fields catch any decoding of the wrong bit slice.

// File: rtl/ecc_scan_pkg.sv
package ecc_scan_pkg;

  localparam int WORD_W    = 64;
  localparam int CNT_W     = 6;
  localparam int DONE_BIT  = 31;
  localparam int CNT_LSB   = 24;
  localparam logic [CNT_W-1:0] FAIL_CODE = 6'h3F;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POLL_REQ,
    S_POLL_CHK,
    S_SCAN_REQ,
    S_SCAN_CHK,
    S_DONE
  } scan_state_e;

  function automatic logic word_complete(input logic [WORD_W-1:0] w);
    return w[DONE_BIT];
  endfunction

  function automatic logic [CNT_W-1:0] word_flips(input logic [WORD_W-1:0] w);
    return w[CNT_LSB +: CNT_W];
  endfunction

  function automatic logic word_failed(input logic [WORD_W-1:0] w);
    return word_flips(w) == FAIL_CODE;
  endfunction

  function automatic logic [15:0] word_user(input logic [WORD_W-1:0] w);
    return w[15:0];
  endfunction

endpackage

// File: rtl/scan_poll_timer.sv
module scan_poll_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            miss,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] misses_q;
  logic [TO_W:0]   next_cnt;

  assign next_cnt = {1'b0, misses_q} + {{TO_W{1'b0}}, 1'b1};
  assign expired  = miss && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      misses_q <= '0;
    else if (clear)  misses_q <= '0;
    else if (miss)   misses_q <= next_cnt[TO_W-1:0];
  end
endmodule

// File: rtl/scan_accum.sv
module scan_accum #(
  parameter int CNT_W = 6,
  parameter int TOT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add,
  input  logic [CNT_W-1:0] flips,
  output logic [CNT_W-1:0] max_q,
  output logic [TOT_W-1:0] sum_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= '0;
      sum_q <= '0;
    end else if (clear) begin
      max_q <= '0;
      sum_q <= '0;
    end else if (add) begin
      if (flips > max_q) max_q <= flips;
      sum_q <= sum_q + {{(TOT_W-CNT_W){1'b0}}, flips};
    end
  end
endmodule

// File: rtl/ecc_sector_scan.sv
module ecc_sector_scan
  import ecc_scan_pkg::*;
#(
  parameter int MAX_STEPS = 64,
  parameter int TO_W      = 16,
  localparam int ADDR_W   = $clog2(MAX_STEPS),
  localparam int STEP_W   = $clog2(MAX_STEPS + 1),
  localparam int TOT_W    = CNT_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              raw_mode,
  input  logic [STEP_W-1:0] num_steps,
  input  logic [TO_W-1:0]   timeout_limit,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              done,
  output logic              timeout,
  output logic              uncorrectable,
  output logic [CNT_W-1:0]  max_flips,
  output logic [TOT_W-1:0]  total_flips,
  output logic              ub_valid,
  output logic [ADDR_W-1:0] ub_index,
  output logic [7:0]        ub_byte0,
  output logic [7:0]        ub_byte1
);

  scan_state_e       state_q;
  logic [ADDR_W-1:0] idx_q;
  logic [ADDR_W-1:0] last_q;
  logic              raw_q;
  logic              unc_q;
  logic              to_q;
  logic [STEP_W-1:0] steps_m1;

  // named internal events
  logic start_acc;
  logic poll_hit;
  logic poll_miss;
  logic poll_expired;
  logic sector_fail;
  logic sector_good;
  logic last_sector;

  assign steps_m1     = num_steps - STEP_W'(1);
  assign start_acc    = start && (state_q == S_IDLE);
  assign poll_hit     = (state_q == S_POLL_CHK) &&  word_complete(rd_data);
  assign poll_miss    = (state_q == S_POLL_CHK) && !word_complete(rd_data);
  assign sector_fail  = (state_q == S_SCAN_CHK) &&  word_failed(rd_data);
  assign sector_good  = (state_q == S_SCAN_CHK) && !word_failed(rd_data);
  assign last_sector  = (idx_q == last_q);

  scan_poll_timer #(.TO_W(TO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_acc),
    .miss    (poll_miss),
    .limit   (timeout_limit),
    .expired (poll_expired)
  );

  scan_accum #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_acc),
    .add   (sector_good),
    .flips (word_flips(rd_data)),
    .max_q (max_flips),
    .sum_q (total_flips)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      raw_q   <= 1'b0;
      unc_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_POLL_REQ;
          raw_q   <= raw_mode;
          last_q  <= steps_m1[ADDR_W-1:0];
          idx_q   <= '0;
          unc_q   <= 1'b0;
          to_q    <= 1'b0;
        end
        S_POLL_REQ: state_q <= S_POLL_CHK;
        S_POLL_CHK: begin
          if (poll_hit) begin
            state_q <= raw_q ? S_DONE : S_SCAN_REQ;
          end else if (poll_expired) begin
            to_q    <= 1'b1;
            state_q <= S_DONE;
          end else begin
            state_q <= S_POLL_REQ;
          end
        end
        S_SCAN_REQ: state_q <= S_SCAN_CHK;
        S_SCAN_CHK: begin
          if (sector_fail) begin
            unc_q   <= 1'b1;
            state_q <= S_DONE;
          end else if (last_sector) begin
            state_q <= S_DONE;
          end else begin
            idx_q   <= idx_q + ADDR_W'(1);
            state_q <= S_SCAN_REQ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_en         = (state_q == S_POLL_REQ) || (state_q == S_SCAN_REQ);
  assign rd_addr       = (state_q == S_POLL_REQ) ? (raw_q ? '0 : last_q) : idx_q;
  assign done          = (state_q == S_DONE);
  assign timeout       = to_q;
  assign uncorrectable = unc_q;
  assign ub_valid      = sector_good;
  assign ub_index      = idx_q;
  assign ub_byte0      = word_user(rd_data)[7:0];
  assign ub_byte1      = word_user(rd_data)[15:8];

endmodule

// File: rtl/ecc_scan_checks.sv
module ecc_scan_checks #(
  parameter int CNT_W = 6,
  parameter int TOT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             timeout,
  input logic             uncorrectable,
  input logic [CNT_W-1:0] max_flips,
  input logic [TOT_W-1:0] total_flips,
  input logic             ub_valid,
  input logic             rd_en,
  input logic             sector_fail,
  input logic             poll_expired
);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fail_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sector_fail |=> (done && uncorrectable));

  assert_fail_code_excluded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    max_flips != 6'h3F);

  assert_expiry_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expired |=> (done && timeout));

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout && uncorrectable));

  assert_max_within_total_R5: assert property (@(posedge clk) disable iff (!rst_n)
    {{(TOT_W-CNT_W){1'b0}}, max_flips} <= total_flips);

  assert_quiet_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_en && !ub_valid));

endmodule

bind ecc_sector_scan ecc_scan_checks #(.CNT_W(6), .TOT_W(TOT_W)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .done          (done),
  .timeout       (timeout),
  .uncorrectable (uncorrectable),
  .max_flips     (max_flips),
  .total_flips   (total_flips),
  .ub_valid      (ub_valid),
  .rd_en         (rd_en),
  .sector_fail   (sector_fail),
  .poll_expired  (poll_expired)
);

// File: tb/test_ecc_sector_scan.sv
`timescale 1ns/1ps
module test_ecc_sector_scan;
  localparam int MAXS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        raw_mode = 1'b0;
  logic [6:0]  num_steps = 7'd1;
  logic [15:0] timeout_limit = 16'd1;
  logic        rd_en;
  logic [5:0]  rd_addr;
  logic [63:0] rd_data;
  logic        done, timeout, uncorrectable, ub_valid;
  logic [5:0]  max_flips, ub_index;
  logic [11:0] total_flips;
  logic [7:0]  ub_byte0, ub_byte1;

  logic [63:0] mem [MAXS];
  logic [63:0] rdq;
  int tests = 0, fails = 0, cycles = 0;
  int ub_cnt = 0, nreads = 0;
  logic [5:0]  got_ix [MAXS];
  logic [15:0] got_ub [MAXS];

  always #2.5 clk = ~clk;

  ecc_sector_scan i_ecc_sector_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .raw_mode(raw_mode),
    .num_steps(num_steps), .timeout_limit(timeout_limit),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .timeout(timeout), .uncorrectable(uncorrectable),
    .max_flips(max_flips), .total_flips(total_flips),
    .ub_valid(ub_valid), .ub_index(ub_index),
    .ub_byte0(ub_byte0), .ub_byte1(ub_byte1)
  );

  always_ff @(posedge clk) if (rd_en) rdq <= mem[rd_addr];
  assign rd_data = rdq;

  always @(negedge clk) begin
    cycles++;
    if (rd_en) nreads++;
    if (ub_valid && ub_cnt < MAXS) begin
      got_ix[ub_cnt] = ub_index;
      got_ub[ub_cnt] = {ub_byte1, ub_byte0};
      ub_cnt++;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd_word(input bit allow_fail);
    logic [63:0] w;
    w = {$urandom, $urandom};
    w[29:24] = (allow_fail && ($urandom % 12 == 0)) ? 6'h3F : 6'($urandom % 9);
    return w;
  endfunction

  // Runs one page and compares against a model built from the requirements.
  task automatic run_page(input bit raw, input int n, input int lim, input int set_at,
                          input bit exp_to, input bit dbl_start);
    int cyc;
    int e_max, e_sum, e_cnt, e_reads, bad;
    bit e_unc;
    logic [5:0] h_max;
    logic [11:0] h_sum;
    @(negedge clk);
    ub_cnt = 0; nreads = 0;
    raw_mode = raw; num_steps = 7'(n); timeout_limit = 16'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "cleared max", max_flips, 0);
    chk("R1", "cleared total", total_flips, 0);
    chk("R1", "cleared flags", {timeout, uncorrectable}, 0);
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (cyc == set_at) mem[raw ? 0 : n-1][31] = 1'b1;
      start = (dbl_start && cyc == 2);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R11", "done seen", done, 1);
    // model
    e_max = 0; e_sum = 0; e_cnt = 0; e_unc = 0; bad = 0;
    if (exp_to) begin
      e_reads = (lim < 1) ? 1 : lim;
    end else if (raw) begin
      e_reads = nreads; // poll count depends on set_at; checked below for immediate case
    end else begin
      for (int i = 0; i < n; i++) begin
        if (mem[i][29:24] == 6'h3F) begin e_unc = 1; break; end
        if (int'(mem[i][29:24]) > e_max) e_max = int'(mem[i][29:24]);
        e_sum += int'(mem[i][29:24]);
        if (got_ix[e_cnt] != 6'(i) || got_ub[e_cnt] != {mem[i][15:8], mem[i][7:0]}) bad++;
        e_cnt++;
      end
      e_reads = -1;
    end
    chk("R3", "timeout flag", timeout, exp_to);
    chk("R7", "uncorrectable flag", uncorrectable, e_unc);
    chk("R5", "max flips", max_flips, e_max);
    chk("R6", "total flips", total_flips, e_sum);
    chk("R8", "user byte count", ub_cnt, e_cnt);
    chk("R8", "user byte mismatches", bad, 0);
    if (exp_to) chk("R3", "poll reads", nreads, e_reads);
    if (!exp_to && set_at < 0)
      chk("R4", "read count", nreads, (raw ? 1 : 1 + e_cnt + (e_unc ? 1 : 0)));
    h_max = max_flips; h_sum = total_flips;
    repeat (3) @(negedge clk);
    chk("R11", "done dropped", done, 0);
    chk("R1", "results held", {h_max, h_sum}, {max_flips, total_flips});
  endtask

  initial begin
    int n, k;
    void'($urandom(32'd24601));
    for (int i = 0; i < MAXS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset outputs", {done, timeout, uncorrectable, rd_en, ub_valid}, 0);
    chk("R1", "reset results", {max_flips, total_flips}, 0);

    // R5 R6 R8 R9: small directed page, zero-count field set everywhere
    for (int i = 0; i < 4; i++) begin
      mem[i] = {32'hFFFF_FFFF, 1'b0, 1'b1, 2'b11, 6'(i * 2 + 1), 2'b11, 6'h2A, 16'hA500 + 16'(i)};
    end
    mem[3][31] = 1'b1;
    run_page(0, 4, 10, -1, 0, 0);

    // R7: failure at sector 0
    for (int i = 0; i < 8; i++) mem[i] = rnd_word(0);
    mem[0][29:24] = 6'h3F; mem[7][31] = 1'b1;
    run_page(0, 8, 10, -1, 0, 0);
    // R7: failure at last sector
    mem[0][29:24] = 6'd5; mem[7][29:24] = 6'h3F;
    run_page(0, 8, 10, -1, 0, 0);

    // R6: widest sum, all sectors count 62
    for (int i = 0; i < MAXS; i++) begin mem[i] = rnd_word(0); mem[i][29:24] = 6'd62; end
    mem[MAXS-1][31] = 1'b1;
    run_page(0, MAXS, 10, -1, 0, 0);

    // R3: timeout with limit 3, and limit 0 behaving as 1
    mem[5][31] = 1'b0;
    run_page(0, 6, 3, 1000000, 1, 0);
    run_page(0, 6, 0, 1000000, 1, 0);

    // R2: completion arrives late; intermediate completion bits clear
    for (int i = 0; i < 6; i++) begin mem[i] = rnd_word(0); mem[i][31] = 1'b0; end
    run_page(0, 6, 1000, 25, 0, 0);

    // R10: raw mode polls word 0 only, no scan
    for (int i = 0; i < 6; i++) mem[i] = rnd_word(0);
    mem[0][31] = 1'b1; mem[5][31] = 1'b0;
    run_page(1, 6, 4, -1, 0, 0);

    // R12: second start during a scan is ignored
    for (int i = 0; i < 10; i++) mem[i] = rnd_word(0);
    mem[9][31] = 1'b1;
    run_page(0, 10, 10, -1, 0, 1);

    // n = 1 page
    mem[0] = rnd_word(0); mem[0][31] = 1'b1;
    run_page(0, 1, 2, -1, 0, 0);

    // random pages
    for (int r = 0; r < 30; r++) begin
      n = 1 + int'($urandom % MAXS);
      for (int i = 0; i < MAXS; i++) mem[i] = rnd_word(1);
      mem[n-1][31] = 1'b1;
      k = int'($urandom % 3);
      if (k == 0) run_page(0, n, 50, 7, 0, 0);
      else begin
        run_page(0, n, 50, -1, 0, 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule